// File: doc/BRIEF.md
# DRAM Command Timing Guard

This block sits between a memory controller's command scheduler and the PHY command path. Each cycle the scheduler presents one candidate command: activate, read, write, refresh, mode-register load or nop. With it come a flag that says the device has eight banks and a flag that says ODT is enabled. The guard answers with a combinational permission signal. The signal stays low while any spacing rule the guard tracks is still open. A command counts as issued only in a cycle where it is both valid and permitted.

The guard tracks four rules. Refresh spacing covers refresh-to-refresh and refresh-to-activate. The rolling four-activate window applies to eight-bank devices. The mode-register update delay covers a mode-register load followed by any other command. The read-to-write turnaround can be lengthened by two penalty bits. All limits come from one 32-bit timing configuration word, which software writes through a write-enable and data port. A new value affects only timers started after the write. Timers already running keep the limit they were loaded with.

Top module: `dram_cmd_guard`

## Requirements
- R1: After reset the configuration word reads 0x09830090. A word written with `cfg_we` high reads back from the next cycle onward.
- R2: After an issued refresh, refresh and activate are refused until the number of cycles since the refresh is at least the value of configuration bits 23:16.
- R3: With `bank8` high, an activate is refused if four activates have already issued and the oldest of those four is fewer than tFAW cycles old. tFAW is the value of configuration bits 8:3 at the time that activate issued.
- R4: With `bank8` low, activates are never refused by the four-activate window.
- R5: After an issued mode-register load, the next read, write, refresh or activate is refused for 12 + code cycles, where code is configuration bits 10:9 (codes 0..3 give 12..15). Another mode-register load is not held back by this rule.
- R6: After an issued read, a write is refused for RTW_BASE cycles (default 4), plus 1 if configuration bit 2 is set, plus 1 more if configuration bit 11 is set and `odt_en` was high with the read.
- R7: `cmd_ok` is high in every cycle in which no tracked rule blocks the presented command, so the guard never stalls a legal command.
- R8: A command starts timers only when `cmd_valid` and `cmd_ok` are both high. Nops never start timers and are always permitted.
- R9: A configuration write changes only timers started after the write. Timers started earlier run to the limit they were loaded with.
- R10: Command codes on `cmd_op` are 0 nop, 1 activate, 2 read, 3 write, 4 refresh, 5 mode-register load. Codes 6 and 7 are treated as nop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Current configuration word |
| cmd_valid | input | 1 | Candidate command is valid |
| cmd_op | input | 3 | Candidate command code |
| bank8 | input | 1 | Device has eight banks |
| odt_en | input | 1 | ODT is enabled for this command |
| cmd_ok | output | 1 | Candidate command is permitted now |

## Verification
The assertions assume the scheduler takes `cmd_ok` as the final word. They also assume `RTW_BASE` is at least 2, so a read always blocks the write in the cycle straight after it. The refresh property is checked only when the loaded spacing exceeds one cycle. The stimulus draws random command streams that are often invalid, reserved codes included, with random bank and ODT flags. It reloads the configuration mid-stream with small random limits so that every window opens and closes many times. The reference model counts a command as issued only when its own permission verdict allows it.

// File: rtl/dcg_pkg.sv
package dcg_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_REF = 3'd4,
    OP_MRS = 3'd5
  } dcg_op_e;

  localparam logic [31:0] CFG_RESET = 32'h0983_0090;

  // field positions inside the configuration word
  localparam int RFC_LO  = 16;
  localparam int RFC_W   = 8;
  localparam int FAW_LO  = 3;
  localparam int FAW_W   = 6;
  localparam int MOD_LO  = 9;
  localparam int MOD_W   = 2;
  localparam int RTW_BIT = 2;
  localparam int ODT_BIT = 11;
  localparam int MOD_MIN = 12;
endpackage

// File: rtl/dcg_cfg_reg.sv
module dcg_cfg_reg
  import dcg_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] word
);
  logic [W-1:0] word_q, word_n;

  always_comb begin
    word_n = word_q;
    if (we) word_n = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= W'(CFG_RESET);
    else        word_q <= word_n;
  end

  assign word = word_q;
endmodule

// File: rtl/dcg_countdown.sv
module dcg_countdown #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy
);
  logic [W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (load)             cnt_n = load_val;
    else if (cnt_q != '0) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/dcg_faw_window.sv
module dcg_faw_window #(
  parameter int DEPTH = 4,
  parameter int W     = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         act_fire,
  input  logic [W-1:0] need,
  output logic         oldest_busy
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PW-1:0]    wp_q, wp_n;
  logic [DEPTH-1:0] slot_busy;
  logic [W-1:0]     load_val;

  assign load_val = (need == '0) ? '0 : need - 1'b1;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_load;
    assign slot_load = act_fire && (wp_q == PW'(i));
    dcg_countdown #(.W(W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (slot_load),
      .load_val (load_val),
      .busy     (slot_busy[i])
    );
  end

  always_comb begin
    wp_n = wp_q;
    if (act_fire) wp_n = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wp_q <= '0;
    else        wp_q <= wp_n;
  end

  // slot at the write pointer holds the oldest of the last DEPTH activates
  assign oldest_busy = slot_busy[wp_q];
endmodule

// File: rtl/dram_cmd_guard.sv
module dram_cmd_guard
  import dcg_pkg::*;
#(
  parameter int RTW_BASE  = 4,
  parameter int FAW_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_op,
  input  logic        bank8,
  input  logic        odt_en,
  output logic        cmd_ok
);
  localparam int RTW_W = $clog2(RTW_BASE + 3);
  localparam int MOD_CW = $clog2(MOD_MIN + 4);

  logic [31:0] cfg;
  logic [RFC_W-1:0] f_rfc;
  logic [FAW_W-1:0] f_faw;
  logic [MOD_W-1:0] f_mod;
  logic is_act, is_rd, is_wr, is_ref, is_mrs, is_nop;
  logic rfc_busy, mod_busy, rtw_busy, faw_busy;
  logic fire;
  logic [RFC_W-1:0]  rfc_load;
  logic [MOD_CW-1:0] mod_load;
  logic [RTW_W-1:0]  rtw_need, rtw_load;

  dcg_cfg_reg #(.W(32)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .word  (cfg)
  );

  assign cfg_rdata = cfg;
  assign f_rfc = cfg[RFC_LO +: RFC_W];
  assign f_faw = cfg[FAW_LO +: FAW_W];
  assign f_mod = cfg[MOD_LO +: MOD_W];

  always_comb begin
    is_act = (cmd_op == OP_ACT);
    is_rd  = (cmd_op == OP_RD);
    is_wr  = (cmd_op == OP_WR);
    is_ref = (cmd_op == OP_REF);
    is_mrs = (cmd_op == OP_MRS);
    is_nop = !(is_act || is_rd || is_wr || is_ref || is_mrs);
  end

  always_comb begin
    cmd_ok = 1'b1;
    if (rfc_busy && (is_act || is_ref))           cmd_ok = 1'b0;
    if (mod_busy && !is_nop && !is_mrs)           cmd_ok = 1'b0;
    if (rtw_busy && is_wr)                        cmd_ok = 1'b0;
    if (faw_busy && bank8 && is_act)              cmd_ok = 1'b0;
  end

  assign fire = cmd_valid && cmd_ok && !is_nop;

  // loads are need-1 so the rule opens exactly need cycles after issue
  assign rfc_load = (f_rfc == '0) ? '0 : f_rfc - 1'b1;
  assign mod_load = MOD_CW'(MOD_MIN - 1) + MOD_CW'(f_mod);
  assign rtw_need = RTW_W'(RTW_BASE) + RTW_W'(cfg[RTW_BIT])
                  + RTW_W'(cfg[ODT_BIT] & odt_en);
  assign rtw_load = (rtw_need == '0) ? '0 : rtw_need - 1'b1;

  dcg_countdown #(.W(RFC_W)) u_rfc (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (fire && is_ref),
    .load_val (rfc_load),
    .busy     (rfc_busy)
  );

  dcg_countdown #(.W(MOD_CW)) u_mod (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (fire && is_mrs),
    .load_val (mod_load),
    .busy     (mod_busy)
  );

  dcg_countdown #(.W(RTW_W)) u_rtw (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (fire && is_rd),
    .load_val (rtw_load),
    .busy     (rtw_busy)
  );

  dcg_faw_window #(.DEPTH(FAW_DEPTH), .W(FAW_W)) u_faw (
    .clk         (clk),
    .rst_n       (rst_n),
    .act_fire    (fire && is_act),
    .need        (f_faw),
    .oldest_busy (faw_busy)
  );
endmodule

// File: rtl/dcg_checker.sv
module dcg_checker #(
  parameter int RTW_BASE = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [31:0] cfg_rdata,
  input logic        cmd_valid,
  input logic [2:0]  cmd_op,
  input logic        cmd_ok
);
  logic issued;
  assign issued = cmd_valid && cmd_ok;

  a_r1_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_we) |-> $stable(cfg_rdata));

  a_r2_ref_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (issued && cmd_op == 3'd4 && cfg_rdata[23:16] > 8'd1)
    |=> !(cmd_ok && (cmd_op == 3'd4 || cmd_op == 3'd1)));

  a_r5_mrs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (issued && cmd_op == 3'd5)
    |=> !(cmd_ok && cmd_op >= 3'd1 && cmd_op <= 3'd4));

  a_r6_rd_wr_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (RTW_BASE >= 2 && issued && cmd_op == 3'd2)
    |=> !(cmd_ok && cmd_op == 3'd3));

  a_r8_nop_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 3'd0 || cmd_op >= 3'd6) |-> cmd_ok);
endmodule

bind dram_cmd_guard dcg_checker #(.RTW_BASE(RTW_BASE)) u_dcg_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_rdata (cfg_rdata),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .cmd_ok    (cmd_ok)
);

// File: tb/dram_cmd_guard_bench.sv
module dram_cmd_guard_bench;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic        bank8;
  logic        odt_en;
  logic        cmd_ok;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference model state
  int cyc = 0;
  int last_ref = -1000, need_ref = 0;
  int last_mrs = -1000, need_mrs = 0;
  int last_rd  = -1000, need_rd  = 0;
  int act_t[$];
  int act_n[$];
  logic [31:0] mcfg;

  dram_cmd_guard u_dram_cmd_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .bank8     (bank8),
    .odt_en    (odt_en),
    .cmd_ok    (cmd_ok)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit good, input string req, input int act, input int exp);
    total++;
    if (!good) begin
      bad++;
      $display("FAIL %s cycle=%0d actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  function automatic bit model_ok(input logic [2:0] op, input logic b8);
    bit ok = 1;
    int n;
    if ((op == 3'd1 || op == 3'd4) && (cyc - last_ref < need_ref)) ok = 0;          // R2
    if (op >= 3'd1 && op <= 3'd4 && (cyc - last_mrs < need_mrs)) ok = 0;           // R5
    if (op == 3'd3 && (cyc - last_rd < need_rd)) ok = 0;                            // R6
    n = act_t.size();
    if (op == 3'd1 && b8 && n >= 4 && (cyc - act_t[n-4] < act_n[n-4])) ok = 0;      // R3, R4
    return ok;
  endfunction

  function automatic string tag_of(input logic [2:0] op, input logic b8);
    case (op)
      3'd1: return b8 ? "R3" : "R4";
      3'd2: return "R7";
      3'd3: return "R6";
      3'd4: return "R2";
      3'd5: return "R5";
      default: return "R10";
    endcase
  endfunction

  // one cycle: drive at the falling edge, then compare and update the model
  task automatic step(input logic v, input logic [2:0] op, input logic b8,
                      input logic odt, input logic we, input logic [31:0] wd);
    bit exp;
    @(negedge clk);
    cmd_valid = v; cmd_op = op; bank8 = b8; odt_en = odt;
    cfg_we = we; cfg_wdata = wd;
    #1;
    exp = model_ok(op, b8);
    check(cmd_ok === exp, tag_of(op, b8), int'(cmd_ok), int'(exp));
    check(cfg_rdata === mcfg, "R1", int'(cfg_rdata), int'(mcfg));
    // R8: only valid and permitted non-nop commands start timers
    if (v && exp && op >= 3'd1 && op <= 3'd5) begin
      case (op)
        3'd1: begin
          act_t.push_back(cyc); act_n.push_back(int'(mcfg[8:3]));
          if (act_t.size() > 4) begin void'(act_t.pop_front()); void'(act_n.pop_front()); end
        end
        3'd2: begin last_rd = cyc; need_rd = 4 + int'(mcfg[2]) + int'(mcfg[11] & odt); end
        3'd4: begin last_ref = cyc; need_ref = int'(mcfg[23:16]); end
        3'd5: begin last_mrs = cyc; need_mrs = 12 + int'(mcfg[10:9]); end
        default: ;
      endcase
    end
    // R9: new configuration applies only from the next cycle's issues
    if (we) mcfg = wd;
    cyc++;
  endtask

  function automatic logic [31:0] rand_cfg();
    logic [31:0] w = '0;
    w[29:24] = 6'($urandom);
    w[23:16] = 8'($urandom % 24);
    w[11]    = 1'($urandom);
    w[10:9]  = 2'($urandom);
    w[8:3]   = 6'($urandom % 32);
    w[2]     = 1'($urandom);
    w[1:0]   = 2'($urandom);
    return w;
  endfunction

  function automatic logic [2:0] rand_op();
    int r = $urandom % 16;
    if (r < 2)  return 3'd0;
    if (r < 7)  return 3'd1;
    if (r < 9)  return 3'd2;
    if (r < 11) return 3'd3;
    if (r == 11) return 3'd4;
    if (r == 12) return ($urandom % 4 == 0) ? 3'd5 : 3'd1;
    if (r == 13) return 3'($urandom % 2 + 6);
    return 3'd1;
  endfunction

  initial begin
    #(200000 * 8);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    mcfg = 32'h0983_0090;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd0; bank8 = 1'b0; odt_en = 1'b0;
    cfg_we = 1'b0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: reset value before release
    total++;
    if (cfg_rdata !== 32'h0983_0090) begin
      bad++; $display("FAIL R1 reset actual=%0h expected=%0h", cfg_rdata, 32'h0983_0090);
    end
    rst_n = 1'b1;
    // R8: nop permitted after reset
    step(1, 3'd0, 0, 0, 0, '0);
    // R2 with default tRFC 131: refresh then activate refused for 131 cycles
    step(1, 3'd4, 0, 0, 0, '0);
    for (int i = 0; i < 140; i++) step(1, 3'd1, 0, 0, 0, '0);
    // R5: mode-register load, others blocked, MRS again allowed
    step(1, 3'd5, 0, 0, 0, '0);
    step(1, 3'd5, 0, 0, 0, '0);
    for (int i = 0; i < 16; i++) step(1, 3'd2, 0, 1, 0, '0);
    // R6 with both penalties: read then writes
    step(1, 3'd0, 0, 0, 1, 32'h0000_0804 | (32'd8 << 3) | (32'd3 << 16));
    step(1, 3'd2, 0, 1, 0, '0);
    for (int i = 0; i < 8; i++) step(1, 3'd3, 0, 0, 0, '0);
    // R3 / R4: bursts of activates with and without the eight-bank flag
    for (int i = 0; i < 20; i++) step(1, 3'd1, 1, 0, 0, '0);
    for (int i = 0; i < 20; i++) step(1, 3'd1, 0, 0, 0, '0);
    // R7, R8, R9, R10: random streams with mid-stream configuration writes
    for (int ph = 0; ph < 40; ph++) begin
      for (int i = 0; i < 600; i++) begin
        bit we = ($urandom % 97 == 0);
        step(($urandom % 5) != 0, rand_op(), ($urandom % 4) != 0, 1'($urandom),
             we, rand_cfg());
      end
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule